// File: doc/BRIEF.md
# MAC Address Learning Table

This block holds a hashed table of MAC addresses for a packet switch and serves two clients. The learning client presents a source address with its ingress port, a frame-good flag and two attribute bits. The block searches a short window of slots that starts at a hashed home slot. It then inserts the address, rewrites its port, leaves it untouched, or drops the request when the window holds no room. Each insert or rewrite marks the entry as new and raises a one-cycle notice carrying the slot index, so that a control processor can copy the entry. The processor clears the new mark with a strobe once it has done so.

The lookup client presents a destination address. Exactly one cycle later the block returns a hit with the stored port, a filtered code, or a no-match code. Lookups have no back-pressure and are always taken. The learning interface is valid/ready: `lrn_ready` drops in any cycle with a lookup request, and a learn request must then hold its valid and payload until it sees ready. A request is taken on the clock edge where `lrn_valid` and `lrn_ready` are both high. The hash mode pin chooses how the home slot is formed. It should only change while the table is empty, because entries placed under one mode are not found under the other.

Top module: `mac_learn_table`

## Requirements
- R1: A learn request taken with `lrn_frame_ok` low changes no entry and raises neither `learn_evt` nor `lrn_full`.
- R2: A taken, good learn of an address missing from its probe window writes the address, port and attribute bits into the first free slot of that window. In the next cycle `learn_evt` is 1 and `learn_idx` holds that slot.
- R3: A good learn of an address already stored with the same port causes no notice and keeps the port. If the stored port differs and the entry is not secure, the entry is rewritten with the new port and attribute bits, and `learn_evt` reports its slot.
- R4: An entry stored with its secure bit set keeps its port when a later learn names a different port, and no notice is raised.
- R5: `rsp_valid` is 1 exactly in the cycle after a cycle with `lkp_valid` high. On a hit, `rsp_code` is 1 and `rsp_port` is the stored port. On a miss, `rsp_code` is 0, `rsp_port` is 0 and `rsp_new` is 0.
- R6: A hit on an entry whose filter bit is set returns `rsp_code` 2 and `rsp_port` 0.
- R7: The probe window is PROBE consecutive slots from the home slot, wrapping modulo the table depth. A good learn of a new address whose whole window is occupied writes nothing, and in the next cycle `lrn_full` is 1 and `learn_evt` is 0.
- R8: `lrn_ready` is 0 in every cycle with `lkp_valid` high. A learn presented in such a cycle is not taken, and it completes once the lookup request goes away.
- R9: With `hash_mode` 0 the home slot is the low IDX_W bits of the address. With `hash_mode` 1 it is the XOR of the address split into IDX_W-bit chunks from bit 0 upward, with the top chunk zero-padded.
- R10: Every insert or rewrite sets the entry's new bit, which a hit reports on `rsp_new`. A cycle with `nf_clr` high clears the new bit of slot `nf_idx`, but a learn writing that same slot in that same cycle wins.
- R11: After reset the table is empty, `lrn_ready` is 1 when no lookup is requested, and `learn_evt`, `lrn_full` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_mode | input | 1 | 0: low address bits, 1: XOR fold |
| lrn_valid | input | 1 | Learn request valid |
| lrn_ready | output | 1 | Learn request can be taken |
| lrn_mac | input | MAC_W | Source address to learn |
| lrn_port | input | PORT_W | Ingress port of the frame |
| lrn_frame_ok | input | 1 | Frame passed its checks |
| lrn_secure | input | 1 | Secure bit to store on write |
| lrn_filter | input | 1 | Filter bit to store on write |
| learn_evt | output | 1 | Pulse: entry inserted or rewritten |
| learn_idx | output | IDX_W | Slot of the notified entry |
| lrn_full | output | 1 | Pulse: learn dropped, window full |
| lkp_valid | input | 1 | Lookup request |
| lkp_mac | input | MAC_W | Destination address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_code | output | 2 | 0 miss, 1 hit, 2 filtered |
| rsp_port | output | PORT_W | Port on a plain hit, else 0 |
| rsp_new | output | 1 | New bit of the hit entry |
| rsp_age | output | AGE_W | Age field of the hit entry |
| nf_clr | input | 1 | Clear a new bit |
| nf_idx | input | IDX_W | Slot whose new bit is cleared |

## Verification
The bench builds the table with IDX_W 4 (16 slots), PROBE 4, PORT_W 5 and a 48-bit address. With only sixteen slots, a handful of addresses that share a low nibble fill a whole probe window. That makes the drop path reachable, and the window can be made to wrap from the last slot back to slot 0 with one occupied slot in the middle. A 4-bit index also keeps the fold hash small enough to work out by hand. An address whose folded home differs from its low nibble then shows that the mode pin changes where an entry lands.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  typedef enum logic [1:0] {
    RSP_MISS = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_FILT = 2'd2
  } rsp_code_e;

  typedef enum logic {
    HASH_LOW  = 1'b0,
    HASH_FOLD = 1'b1
  } hash_mode_e;
endpackage

// File: rtl/mlt_hash.sv
module mlt_hash #(
  parameter int MAC_W = 48,
  parameter int IDX_W = 11
) (
  input  mlt_pkg::hash_mode_e mode,
  input  logic [MAC_W-1:0]    mac,
  output logic [IDX_W-1:0]    home
);
  localparam int NCH = (MAC_W + IDX_W - 1) / IDX_W;

  logic [NCH*IDX_W-1:0] padded;
  logic [IDX_W-1:0]     fold;

  always_comb begin
    padded = '0;
    padded[MAC_W-1:0] = mac;
    fold = '0;
    for (int k = 0; k < NCH; k++) fold ^= padded[k*IDX_W +: IDX_W];
  end

  assign home = (mode == mlt_pkg::HASH_FOLD) ? fold : mac[IDX_W-1:0];
endmodule

// File: rtl/mlt_probe.sv
module mlt_probe #(
  parameter int MAC_W = 48,
  parameter int PROBE = 4,
  localparam int OFS_W = (PROBE > 1) ? $clog2(PROBE) : 1
) (
  input  logic [MAC_W-1:0] key,
  input  logic [MAC_W-1:0] slot_mac [PROBE],
  input  logic [PROBE-1:0] slot_occ,
  output logic             hit,
  output logic [OFS_W-1:0] hit_ofs,
  output logic             free,
  output logic [OFS_W-1:0] free_ofs
);
  // Scan from the far end so the nearest slot wins.
  always_comb begin
    hit = 1'b0;
    hit_ofs = '0;
    free = 1'b0;
    free_ofs = '0;
    for (int k = PROBE - 1; k >= 0; k--) begin
      if (slot_occ[k] && slot_mac[k] == key) begin
        hit = 1'b1;
        hit_ofs = OFS_W'(k);
      end
      if (!slot_occ[k]) begin
        free = 1'b1;
        free_ofs = OFS_W'(k);
      end
    end
  end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int MAC_W  = 48,
  parameter int PORT_W = 5,
  parameter int IDX_W  = 11,
  parameter int PROBE  = 4,
  parameter int AGE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hash_mode,
  input  logic              lrn_valid,
  output logic              lrn_ready,
  input  logic [MAC_W-1:0]  lrn_mac,
  input  logic [PORT_W-1:0] lrn_port,
  input  logic              lrn_frame_ok,
  input  logic              lrn_secure,
  input  logic              lrn_filter,
  output logic              learn_evt,
  output logic [IDX_W-1:0]  learn_idx,
  output logic              lrn_full,
  input  logic              lkp_valid,
  input  logic [MAC_W-1:0]  lkp_mac,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [PORT_W-1:0] rsp_port,
  output logic              rsp_new,
  output logic [AGE_W-1:0]  rsp_age,
  input  logic              nf_clr,
  input  logic [IDX_W-1:0]  nf_idx
);
  import mlt_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int OFS_W = (PROBE > 1) ? $clog2(PROBE) : 1;
  localparam logic [AGE_W-1:0] AGE_FRESH = '1;

  // Table storage: presence and flags are reset, payload is not.
  logic [DEPTH-1:0]  occ, sec, flt, nwf;
  logic [MAC_W-1:0]  tbl_mac  [DEPTH];
  logic [PORT_W-1:0] tbl_port [DEPTH];
  logic [AGE_W-1:0]  tbl_age  [DEPTH];

  hash_mode_e mode;
  assign mode = hash_mode_e'(hash_mode);

  logic [IDX_W-1:0] l_home, k_home;

  mlt_hash #(.MAC_W(MAC_W), .IDX_W(IDX_W)) u_hash_lrn (
    .mode(mode), .mac(lrn_mac), .home(l_home));
  mlt_hash #(.MAC_W(MAC_W), .IDX_W(IDX_W)) u_hash_lkp (
    .mode(mode), .mac(lkp_mac), .home(k_home));

  logic [MAC_W-1:0] l_mac [PROBE];
  logic [MAC_W-1:0] k_mac [PROBE];
  logic [PROBE-1:0] l_occ, k_occ;

  for (genvar g = 0; g < PROBE; g++) begin : g_win
    logic [IDX_W-1:0] li, ki;
    assign li = l_home + IDX_W'(g);
    assign ki = k_home + IDX_W'(g);
    assign l_mac[g] = tbl_mac[li];
    assign l_occ[g] = occ[li];
    assign k_mac[g] = tbl_mac[ki];
    assign k_occ[g] = occ[ki];
  end

  logic             l_hit, l_free, k_hit, k_free;
  logic [OFS_W-1:0] l_hit_ofs, l_free_ofs, k_hit_ofs, k_free_ofs;

  mlt_probe #(.MAC_W(MAC_W), .PROBE(PROBE)) u_probe_lrn (
    .key(lrn_mac), .slot_mac(l_mac), .slot_occ(l_occ),
    .hit(l_hit), .hit_ofs(l_hit_ofs), .free(l_free), .free_ofs(l_free_ofs));
  mlt_probe #(.MAC_W(MAC_W), .PROBE(PROBE)) u_probe_lkp (
    .key(lkp_mac), .slot_mac(k_mac), .slot_occ(k_occ),
    .hit(k_hit), .hit_ofs(k_hit_ofs), .free(k_free), .free_ofs(k_free_ofs));

  // Learn decision.
  logic             lrn_take, lrn_go, do_ins, do_rew, do_ref, do_drop, do_wr;
  logic [IDX_W-1:0] l_hit_idx, l_free_idx, w_idx, k_idx;

  assign lrn_ready  = !lkp_valid;
  assign lrn_take   = lrn_valid && lrn_ready;
  assign lrn_go     = lrn_take && lrn_frame_ok;
  assign l_hit_idx  = l_home + IDX_W'(l_hit_ofs);
  assign l_free_idx = l_home + IDX_W'(l_free_ofs);
  assign k_idx      = k_home + IDX_W'(k_hit_ofs);
  assign w_idx      = l_hit ? l_hit_idx : l_free_idx;

  assign do_ins  = lrn_go && !l_hit && l_free;
  assign do_rew  = lrn_go && l_hit && !sec[l_hit_idx] && (tbl_port[l_hit_idx] != lrn_port);
  assign do_ref  = lrn_go && l_hit && !do_rew;
  assign do_drop = lrn_go && !l_hit && !l_free;
  assign do_wr   = do_ins || do_rew;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ       <= '0;
      sec       <= '0;
      flt       <= '0;
      nwf       <= '0;
      learn_evt <= 1'b0;
      learn_idx <= '0;
      lrn_full  <= 1'b0;
    end else begin
      learn_evt <= do_wr;
      learn_idx <= w_idx;
      lrn_full  <= do_drop;
      if (nf_clr) nwf[nf_idx] <= 1'b0;
      if (do_wr) begin
        occ[w_idx] <= 1'b1;
        sec[w_idx] <= lrn_secure;
        flt[w_idx] <= lrn_filter;
        nwf[w_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tbl_mac[w_idx]  <= lrn_mac;
      tbl_port[w_idx] <= lrn_port;
    end
    if (do_wr || do_ref) tbl_age[w_idx] <= AGE_FRESH;
  end

  // Lookup response, fixed one-cycle latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_MISS;
      rsp_port  <= '0;
      rsp_new   <= 1'b0;
      rsp_age   <= '0;
    end else begin
      rsp_valid <= lkp_valid;
      rsp_code  <= RSP_MISS;
      rsp_port  <= '0;
      rsp_new   <= 1'b0;
      rsp_age   <= '0;
      if (lkp_valid && k_hit) begin
        rsp_code <= flt[k_idx] ? RSP_FILT : RSP_HIT;
        rsp_port <= flt[k_idx] ? '0 : tbl_port[k_idx];
        rsp_new  <= nwf[k_idx];
        rsp_age  <= tbl_age[k_idx];
      end
    end
  end

  // R8: a learn offered beside a lookup is not taken that cycle
  a_r8_lookup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lrn_valid) |=> (!learn_evt && !lrn_full));

  // R1: bad frames leave no trace
  a_r1_bad_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lrn_valid && lrn_ready && !lrn_frame_ok) |=> (!learn_evt && !lrn_full));

  // R5: response follows request by exactly one cycle
  a_r5_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rsp_valid);
  a_r5_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !rsp_valid);

  // R6: non-hit results carry no port
  a_r6_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RSP_HIT) |-> (rsp_port == '0));

  // R7: a drop and a notice never coincide
  a_r7_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(learn_evt && lrn_full));

  // R2: a notice only follows a taken request
  a_r2_evt_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    learn_evt |-> $past(lrn_valid && !lkp_valid));
endmodule

// File: tb/mac_learn_table_tb_top.sv
`timescale 1ns/1ps
module mac_learn_table_tb_top;
  localparam int MAC_W = 48, PORT_W = 5, IDX_W = 4, PROBE = 4, AGE_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              hash_mode = 1'b0;
  logic              lrn_valid = 1'b0, lrn_ready;
  logic [MAC_W-1:0]  lrn_mac = '0;
  logic [PORT_W-1:0] lrn_port = '0;
  logic              lrn_frame_ok = 1'b0, lrn_secure = 1'b0, lrn_filter = 1'b0;
  logic              learn_evt, lrn_full;
  logic [IDX_W-1:0]  learn_idx;
  logic              lkp_valid = 1'b0;
  logic [MAC_W-1:0]  lkp_mac = '0;
  logic              rsp_valid, rsp_new;
  logic [1:0]        rsp_code;
  logic [PORT_W-1:0] rsp_port;
  logic [AGE_W-1:0]  rsp_age;
  logic              nf_clr = 1'b0;
  logic [IDX_W-1:0]  nf_idx = '0;

  mac_learn_table #(.MAC_W(MAC_W), .PORT_W(PORT_W), .IDX_W(IDX_W),
                    .PROBE(PROBE), .AGE_W(AGE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode),
    .lrn_valid(lrn_valid), .lrn_ready(lrn_ready), .lrn_mac(lrn_mac),
    .lrn_port(lrn_port), .lrn_frame_ok(lrn_frame_ok), .lrn_secure(lrn_secure),
    .lrn_filter(lrn_filter), .learn_evt(learn_evt), .learn_idx(learn_idx),
    .lrn_full(lrn_full), .lkp_valid(lkp_valid), .lkp_mac(lkp_mac),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_port(rsp_port),
    .rsp_new(rsp_new), .rsp_age(rsp_age), .nf_clr(nf_clr), .nf_idx(nf_idx));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer one learn with no lookup; check the notice one cycle later.
  task automatic do_learn(input string req, input logic [MAC_W-1:0] mac,
                          input logic [PORT_W-1:0] port, input logic ok,
                          input logic secure, input logic filter,
                          input logic exp_evt, input logic [IDX_W-1:0] exp_idx,
                          input logic exp_full);
    @(negedge clk);
    lrn_valid = 1'b1; lrn_mac = mac; lrn_port = port;
    lrn_frame_ok = ok; lrn_secure = secure; lrn_filter = filter;
    @(negedge clk);
    lrn_valid = 1'b0;
    chk({req, " evt"}, 64'(learn_evt), 64'(exp_evt));
    if (exp_evt) chk({req, " idx"}, 64'(learn_idx), 64'(exp_idx));
    chk({req, " full"}, 64'(lrn_full), 64'(exp_full));
  endtask

  task automatic do_lookup(input string req, input logic [MAC_W-1:0] mac,
                           input logic [1:0] exp_code, input logic [PORT_W-1:0] exp_port,
                           input logic exp_new);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_mac = mac;
    @(negedge clk);
    lkp_valid = 1'b0;
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " code"}, 64'(rsp_code), 64'(exp_code));
    chk({req, " port"}, 64'(rsp_port), 64'(exp_port));
    chk({req, " new"}, 64'(rsp_new), 64'(exp_new));
  endtask

  localparam logic [MAC_W-1:0] MA = 48'h0A00_0000_0001;  // home 1
  localparam logic [MAC_W-1:0] MB = 48'h0B00_0000_0005;  // home 5
  localparam logic [MAC_W-1:0] MC = 48'h0C00_0000_0008;  // home 8
  localparam logic [MAC_W-1:0] ME = 48'h0000_0000_00A3;  // low 3, fold 9
  localparam logic [MAC_W-1:0] MF = 48'h0F00_0000_000B;  // home 11

  task automatic t_reset();
    chk("R11 ready", 64'(lrn_ready), 64'd1);
    chk("R11 evt", 64'(learn_evt), 64'd0);
    chk("R11 full", 64'(lrn_full), 64'd0);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    do_lookup("R11 empty", MA, 2'd0, '0, 1'b0);
  endtask

  task automatic t_bad_frame();
    do_learn("R1 bad frame", MA, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    do_lookup("R1 not stored", MA, 2'd0, '0, 1'b0);
  endtask

  task automatic t_insert();
    do_learn("R2 insert", MA, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0);
    do_lookup("R5 hit", MA, 2'd1, 5'd3, 1'b1);
  endtask

  task automatic t_relearn();
    do_learn("R3 same port", MA, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    do_learn("R3 moved", MA, 5'd7, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0);
    do_lookup("R3 new port", MA, 2'd1, 5'd7, 1'b1);
  endtask

  task automatic t_new_flag();
    @(negedge clk);
    nf_clr = 1'b1; nf_idx = 4'd1;
    @(negedge clk);
    nf_clr = 1'b0;
    do_lookup("R10 cleared", MA, 2'd1, 5'd7, 1'b0);
    do_learn("R10 relearn", MA, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0);
    do_lookup("R10 set again", MA, 2'd1, 5'd2, 1'b1);
  endtask

  task automatic t_secure();
    do_learn("R4 add secure", MB, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 1'b0);
    do_learn("R4 move blocked", MB, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    do_lookup("R4 port kept", MB, 2'd1, 5'd4, 1'b1);
  endtask

  task automatic t_filter();
    do_learn("R6 add filtered", MC, 5'd6, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8, 1'b0);
    do_lookup("R6 filtered", MC, 2'd2, 5'd0, 1'b1);
  endtask

  // Four addresses with home 15: window 15,0,1,2 where slot 1 holds MA.
  task automatic t_probe_wrap();
    do_learn("R7 d0", 48'h1000_0000_000F, 5'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0);
    do_learn("R7 d1 wraps", 48'h2000_0000_000F, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0);
    do_learn("R7 d2 skips", 48'h3000_0000_000F, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0);
    do_learn("R7 d3 dropped", 48'h4000_0000_000F, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    do_lookup("R7 d3 absent", 48'h4000_0000_000F, 2'd0, '0, 1'b0);
    do_lookup("R7 d1 found", 48'h2000_0000_000F, 2'd1, 5'd2, 1'b1);
  endtask

  task automatic t_hash_mode();
    @(negedge clk);
    hash_mode = 1'b1;
    do_learn("R9 fold home", ME, 5'd12, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0);
    do_lookup("R9 fold hit", ME, 2'd1, 5'd12, 1'b1);
    @(negedge clk);
    hash_mode = 1'b0;
    do_lookup("R9 low mode miss", ME, 2'd0, '0, 1'b0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    lrn_valid = 1'b1; lrn_mac = MF; lrn_port = 5'd1; lrn_frame_ok = 1'b1;
    lrn_secure = 1'b0; lrn_filter = 1'b0;
    lkp_valid = 1'b1; lkp_mac = MB;
    #1 chk("R8 ready low", 64'(lrn_ready), 64'd0);
    @(negedge clk);
    lkp_valid = 1'b0;
    chk("R8 rsp served", 64'(rsp_valid), 64'd1);
    chk("R8 learn held", 64'(learn_evt), 64'd0);
    #1 chk("R8 ready back", 64'(lrn_ready), 64'd1);
    @(negedge clk);
    lrn_valid = 1'b0;
    chk("R8 learn done", 64'(learn_evt), 64'd1);
    chk("R8 learn idx", 64'(learn_idx), 64'd11);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_frame();
    t_insert();
    t_relearn();
    t_new_flag();
    t_secure();
    t_filter();
    t_probe_wrap();
    t_hash_mode();
    t_priority();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule